// File: doc/BRIEF.md
# Partial-Word Store Byte-Enable Generator

This block turns a partial store request into a single aligned write beat for a big-endian memory port that is eight bytes wide. A request carries a byte address, a 64-bit register value, a direction flag and a unit size. The direction flag selects a store that runs from the addressed byte to the end of its unit ("begin") or from the start of the unit up to, but not including, the addressed byte ("end"). The unit size is a 4-byte word or an 8-byte doubleword. The low address bits give the offset `k` inside the unit. They decide only which byte lanes are enabled. The value is never shifted, because the big-endian lane order already puts the low-order bytes at the tail of a unit and the high-order bytes at its head.

Every request becomes exactly one write beat, so stores of 3, 5, 6 or 7 bytes reach the memory as one indivisible write. An end-style store with `k = 0` enables no byte. It still issues a beat, flagged as a probe, so that the memory side can check write permission and mark the line dirty. The beat sits in an output register behind a valid/ready handshake. When the memory side does not stall, a new request is accepted every cycle.

Top module: `pstore_be_gen`

## Requirements
- R1: After synchronous reset, `wr_valid` is 0 and `req_ready` is 1.
- R2: Enable bit i of `wr_be` belongs to byte offset i of the doubleword, which travels on `wr_data[63-8*i -: 8]`. For a doubleword begin store with offset k = `req_addr[2:0]`, the enabled offsets are k through 7, so k = 0 enables all eight.
- R3: A word store uses k = `req_addr[1:0]`. Its unit is offsets 0..3 when `req_addr[2]` is 0 and offsets 4..7 when it is 1. A begin store enables unit offsets k through 3, and no lane outside the unit is enabled.
- R4: An end store enables unit offsets 0 through k-1 and no other lane.
- R5: `wr_probe` is 1 exactly when the store is end-style with k = 0. Such a beat has `wr_be` equal to 0. Every other beat has at least one enable set.
- R6: `wr_addr` equals `req_addr` with bits [2:0] cleared.
- R7: `wr_data` equals the value for a doubleword store. For a word store it is `req_data[31:0]` placed in both halves. As a result, a begin store writes the value's lowest-order bytes right-aligned to the unit end, and an end store writes its highest-order bytes from the unit start.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, every `wr_*` output holds its value and `req_ready` is 0.
- R9: With `wr_ready` held at 1, requests offered on consecutive cycles are all accepted. Each one appears on the write port one cycle after its acceptance.
- R10: Each accepted request produces exactly one write handshake. No partial store is ever split across beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_end | input | 1 | 0 = begin-style store, 1 = end-style store |
| req_dword | input | 1 | 0 = word unit, 1 = doubleword unit |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | 64 | Register value |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | ADDR_W | Doubleword-aligned write address |
| wr_data | output | 64 | Write data, big-endian lanes |
| wr_be | output | 8 | Byte enables, bit i = byte offset i |
| wr_probe | output | 1 | Beat writes nothing, permission probe only |

## Verification
Both directions and both unit sizes are swept over all eight low-address values, each with two distinct values. The sweep separates an off-by-one at the offset boundary from a reversed direction, and it catches a word mask landing in the wrong half. The bench compares the enables, the data lanes and the bytes that reach a memory model pre-filled with a marker byte. This shows that begin stores leave low-order bytes at the unit end and end stores leave high-order bytes at the unit start. Zero-offset end stores separate the probe beat from a full write. A stalled port with a queued request and a back-to-back burst show that a beat holds and that no request is lost or split.

// File: rtl/pstore_pkg.sv
package pstore_pkg;
  localparam int BUS_BYTES  = 8;
  localparam int WORD_BYTES = 4;
  localparam int BUS_W      = BUS_BYTES * 8;
  localparam int DOFF_W     = $clog2(BUS_BYTES);
  localparam int WOFF_W     = $clog2(WORD_BYTES);

  typedef enum logic {DIR_BEGIN = 1'b0, DIR_END = 1'b1} store_dir_e;
  typedef enum logic {UNIT_WORD = 1'b0, UNIT_DWORD = 1'b1} unit_size_e;

  typedef struct packed {
    logic [BUS_W-1:0]     data;
    logic [BUS_BYTES-1:0] be;
    logic                 probe;
  } beat_t;
endpackage

// File: rtl/pstore_run_mask.sv
module pstore_run_mask #(
  parameter int NBYTES = 8,
  localparam int OFF_W = $clog2(NBYTES)
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic              is_end,
  output logic [NBYTES-1:0] mask,
  output logic              empty
);
  // bit i covers byte offset i of the unit (offset 0 = most significant byte)
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam logic [OFF_W:0] IDX = (OFF_W+1)'(i);
    assign mask[i] = is_end ? (IDX < {1'b0, offset}) : (IDX >= {1'b0, offset});
  end
  assign empty = is_end && (offset == '0);
endmodule

// File: rtl/pstore_lane_map.sv
module pstore_lane_map
  import pstore_pkg::*;
(
  input  unit_size_e            size,
  input  logic                  word_hi,
  input  logic [WORD_BYTES-1:0] wmask,
  input  logic                  wempty,
  input  logic [BUS_BYTES-1:0]  dmask,
  input  logic                  dempty,
  input  logic [BUS_W-1:0]      value,
  output beat_t                 beat
);
  localparam int WORD_W = WORD_BYTES * 8;
  localparam int HALVES = BUS_BYTES / WORD_BYTES;

  logic [BUS_BYTES-1:0] word_be;
  logic [BUS_W-1:0]     word_data;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    // half h holds byte offsets h*WORD_BYTES .. h*WORD_BYTES+WORD_BYTES-1
    assign word_be[h*WORD_BYTES +: WORD_BYTES] =
      (word_hi == h[0]) ? wmask : '0;
    assign word_data[BUS_W-1-h*WORD_W -: WORD_W] = value[WORD_W-1:0];
  end

  always_comb begin
    if (size == UNIT_DWORD) begin
      beat.data  = value;
      beat.be    = dmask;
      beat.probe = dempty;
    end else begin
      beat.data  = word_data;
      beat.be    = word_be;
      beat.probe = wempty;
    end
  end
endmodule

// File: rtl/pstore_beat_reg.sv
module pstore_beat_reg
  import pstore_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  beat_t             in_beat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output beat_t             out_beat
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_addr <= in_addr;
      out_beat <= in_beat;
    end
  end
endmodule

// File: rtl/pstore_be_gen.sv
module pstore_be_gen
  import pstore_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_end,
  input  logic              req_dword,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [63:0]       wr_data,
  output logic [7:0]        wr_be,
  output logic              wr_probe
);
  logic [WORD_BYTES-1:0] wmask;
  logic [BUS_BYTES-1:0]  dmask;
  logic                  wempty, dempty;
  beat_t                 beat_in, beat_out;
  logic [ADDR_W-1:0]     aligned;

  pstore_run_mask #(.NBYTES(WORD_BYTES)) u_wmask (
    .offset(req_addr[WOFF_W-1:0]), .is_end(req_end),
    .mask(wmask), .empty(wempty)
  );

  pstore_run_mask #(.NBYTES(BUS_BYTES)) u_dmask (
    .offset(req_addr[DOFF_W-1:0]), .is_end(req_end),
    .mask(dmask), .empty(dempty)
  );

  pstore_lane_map u_map (
    .size(unit_size_e'(req_dword)), .word_hi(req_addr[WOFF_W]),
    .wmask(wmask), .wempty(wempty), .dmask(dmask), .dempty(dempty),
    .value(req_data), .beat(beat_in)
  );

  assign aligned = {req_addr[ADDR_W-1:DOFF_W], {DOFF_W{1'b0}}};

  pstore_beat_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk(clk), .rst(rst),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_addr(aligned), .in_beat(beat_in),
    .out_valid(wr_valid), .out_ready(wr_ready),
    .out_addr(wr_addr), .out_beat(beat_out)
  );

  assign wr_data  = beat_out.data;
  assign wr_be    = beat_out.be;
  assign wr_probe = beat_out.probe;
endmodule

// File: rtl/pstore_be_gen_chk.sv
module pstore_be_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [63:0]       wr_data,
  input logic [7:0]        wr_be,
  input logic              wr_probe
);
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !wr_valid);

  assert_probe_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_probe) |-> (wr_be == 8'h00));

  assert_write_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_probe) |-> (wr_be != 8'h00));

  assert_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr[2:0] == 3'b000));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)
                                 && $stable(wr_be) && $stable(wr_probe)));

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |-> !req_ready);

  assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> wr_valid);
endmodule

bind pstore_be_gen pstore_be_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_be(wr_be), .wr_probe(wr_probe)
);

// File: tb/test_pstore_be_gen.sv
module test_pstore_be_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_end = 1'b0, req_dword = 1'b0, wr_ready = 1'b1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0] req_data = '0;
  logic req_ready, wr_valid, wr_probe;
  logic [ADDR_W-1:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0] wr_be;

  int checks = 0, fails = 0, hs_count = 0, req_count = 0;
  logic fill_req = 1'b0;
  logic [3:0] fill_idx = '0;
  logic [7:0] mem [0:127];

  always #(CLK_PERIOD/2) clk = ~clk;

  pstore_be_gen #(.ADDR_W(ADDR_W)) i_pstore_be_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_end(req_end), .req_dword(req_dword), .req_addr(req_addr),
    .req_data(req_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_probe(wr_probe)
  );

  // memory model: byte b of a doubleword lives on data[63-8b -: 8]
  always @(posedge clk) begin
    if (fill_req) begin
      for (int b = 0; b < 8; b++) mem[{fill_idx, 3'(b)}] <= 8'hA5;
    end else if (wr_valid && wr_ready) begin
      for (int b = 0; b < 8; b++)
        if (wr_be[b]) mem[{wr_addr[6:3], 3'(b)}] <= wr_data[63-8*b -: 8];
    end
    if (wr_valid && wr_ready) hs_count <= hs_count + 1;
    if (!rst && req_valid && req_ready) req_count <= req_count + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // expected values from the requirements
  function automatic logic [7:0] exp_be(input bit e, input bit d, input logic [2:0] low);
    int n = d ? 8 : 4;
    int k = d ? int'(low) : int'(low[1:0]);
    int base = d ? 0 : (low[2] ? 4 : 0);
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++)
      if (i >= base && i < base + n)
        m[i] = e ? ((i - base) < k) : ((i - base) >= k);
    return m;
  endfunction

  function automatic logic [7:0] exp_byte(input bit d, input logic [63:0] v, input int i);
    int j = i % 4;
    return d ? v[63-8*i -: 8] : v[31-8*j -: 8];
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    logic [63:0] pats [2];
    int n;
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'hF1E2_D3C4_B5A6_9788;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_valid, "R1 wr_valid after reset", 64'(wr_valid), 64'h0);
    chk(req_ready, "R1 req_ready after reset", 64'(req_ready), 64'h1);

    // sweep: direction x size x low bits x pattern
    n = 0;
    for (int e = 0; e < 2; e++)
      for (int d = 0; d < 2; d++)
        for (int lo = 0; lo < 8; lo++)
          for (int p = 0; p < 2; p++) begin
            logic [ADDR_W-1:0] a;
            logic [7:0] ebe;
            logic [63:0] edata;
            bit eprobe, k0;
            string rq;
            a = 32'h4000_0000 | (32'(n % 16) << 3) | 32'(lo);
            ebe = exp_be(e[0], d[0], 3'(lo));
            edata = d ? pats[p] : {pats[p][31:0], pats[p][31:0]};
            k0 = d ? (lo == 0) : ((lo % 4) == 0);
            eprobe = e[0] && k0;
            rq = e ? "R4" : (d ? "R2" : "R3");
            fill_idx = a[6:3];
            fill_req = 1'b1;
            @(negedge clk);
            fill_req = 1'b0;
            req_valid = 1'b1; req_end = e[0]; req_dword = d[0];
            req_addr = a; req_data = pats[p];
            @(negedge clk);
            req_valid = 1'b0;
            chk(wr_valid, "R9 beat present", 64'(wr_valid), 64'h1);
            chk(wr_be == ebe, rq, 64'(wr_be), 64'(ebe));
            chk(wr_probe == eprobe, "R5 probe flag", 64'(wr_probe), 64'(eprobe));
            chk(wr_addr == {a[ADDR_W-1:3], 3'b000}, "R6 aligned address", 64'(wr_addr), 64'({a[ADDR_W-1:3], 3'b000}));
            chk(wr_data == edata, "R7 write data", wr_data, edata);
            @(negedge clk);
            for (int i = 0; i < 8; i++) begin
              logic [7:0] eb;
              eb = ebe[i] ? exp_byte(d[0], pats[p], i) : 8'hA5;
              chk(mem[{a[6:3], 3'(i)}] == eb, "R7 memory byte", 64'(mem[{a[6:3], 3'(i)}]), 64'(eb));
            end
            n++;
          end

    // R8: stall with a queued request
    wr_ready = 1'b0;
    req_valid = 1'b1; req_end = 1'b0; req_dword = 1'b1;
    req_addr = 32'h0000_0108; req_data = 64'h1111_2222_3333_4444;
    @(negedge clk);
    req_addr = 32'h0000_0213; req_data = 64'h5555_6666_7777_8888;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(wr_valid && wr_addr == 32'h0000_0108, "R8 beat held", 64'(wr_addr), 64'h108);
      chk(wr_data == 64'h1111_2222_3333_4444, "R8 data held", wr_data, 64'h1111_2222_3333_4444);
      chk(!req_ready, "R8 req_ready low", 64'(req_ready), 64'h0);
    end
    wr_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(wr_valid && wr_addr == 32'h0000_0210, "R8 queued request after release", 64'(wr_addr), 64'h210);
    chk(wr_be == 8'hF8, "R2 queued begin mask", 64'(wr_be), 64'hF8);
    @(negedge clk);

    // R9: back-to-back burst
    for (int t = 0; t <= 6; t++) begin
      if (t > 0) begin
        chk(wr_valid && wr_addr == 32'(t - 1) << 3, "R9 burst beat", 64'(wr_addr), 64'(32'(t - 1) << 3));
        chk(wr_be == exp_be(1'b1, 1'b0, 3'(t - 1)), "R9 burst mask", 64'(wr_be), 64'(exp_be(1'b1, 1'b0, 3'(t - 1))));
      end
      if (t < 6) begin
        chk(req_ready, "R9 ready in burst", 64'(req_ready), 64'h1);
        req_valid = 1'b1; req_end = 1'b1; req_dword = 1'b0;
        req_addr = (32'(t) << 3) | 32'(t); req_data = 64'(t);
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    @(negedge clk);
    chk(hs_count == req_count, "R10 one beat per request", 64'(hs_count), 64'(req_count));
    finish_run();
  end
endmodule